// File: doc/BRIEF.md
# Pipelined DES Block Cipher Engine

This engine applies the Data Encryption Standard to one 64-bit block per clock. Each block arrives with its own 64-bit key and a direction flag, and both travel down the pipeline alongside the block. Consecutive blocks can therefore use unrelated keys and can mix encryption with decryption. The datapath is fully unrolled: the input stage performs the initial permutation and the key reduction, sixteen Feistel stages each own one register, and the last stage also performs the swap and the inverse permutation. A result leaves the engine exactly seventeen cycles after its block was taken, and after that a result can leave on every cycle.

Each stage derives its own subkey from the rotated key halves carried with the block. Encryption rotates the halves left, by one or two places depending on the round. Decryption starts with the unrotated halves and rotates them right, so it walks the subkeys in reverse order. The engine has no stall and no backpressure. A qualifier bit marks which output cycles carry a result.

Top module: `des_pipe_core`

## Requirements
- R1: With `in_decrypt` = 0 the result is the DES encryption of `in_block` under `in_key`. Known answers: key 133457799BBCDFF1 with block 0123456789ABCDEF gives 85E813540F0AB405; an all-zero key with an all-zero block gives 8CA64DE9C1B123A7; key 0E329232EA6D0D73 with block 8787878787878787 gives 0000000000000000.
- R2: `out_valid` is high in the cycle that comes exactly 17 cycles after a cycle in which `in_valid` was high and sampled. In every other cycle it is low.
- R3: Blocks presented on consecutive cycles produce results on consecutive cycles, in the same order.
- R4: With `in_decrypt` = 1 the engine inverts the cipher. Decrypting 85E813540F0AB405 under key 133457799BBCDFF1 gives 0123456789ABCDEF, and decrypting any ciphertext under the key that produced it gives back the plaintext.
- R5: Key and direction are captured per block. Interleaving blocks with different keys and directions on adjacent cycles gives each block the result it would have on its own.
- R6: A synchronous reset clears every stage's valid bit. No block in flight at reset ever produces `out_valid`, and `out_valid` stays low until 17 cycles after the first block accepted after reset.
- R7: The least significant bit of each key byte (the parity bits) has no effect. Key 12355678 9ABDDEF0 with block 0123456789ABCDEF still gives 85E813540F0AB405.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears valid bits only |
| in_valid | input | 1 | A block is presented this cycle |
| in_decrypt | input | 1 | 1 selects decryption, 0 selects encryption, for this block |
| in_key | input | 64 | Key for this block; byte parity bits are ignored |
| in_block | input | 64 | Data block, most significant bit is DES bit 1 |
| out_valid | output | 1 | `out_block` carries a result this cycle |
| out_block | output | 64 | Result block, meaningful only while `out_valid` is high |

## Verification
The algorithm fixes the widths and the depth, so the bench builds the engine in its only geometry: 64-bit blocks and keys, sixteen round stages and a 17-cycle latency. That geometry makes published known answers usable as direct checks. The bench also captures the ciphertext of randomly keyed blocks and feeds it back for decryption, which checks the inverse without a second cipher model. A behavioural queue that is exactly as deep as the latency checks the qualifier on every clock. Because of that queue, blocks accepted back to back, interleaved keys and directions, and a reset with blocks in flight all fall under cycle-exact checking.

// File: rtl/des_pkg.sv
`timescale 1ns/100ps
package des_pkg;
    localparam int BLK_W  = 64;
    localparam int HALF_W = BLK_W / 2;
    localparam int CD_W   = 28;
    localparam int SUBK_W = 48;
    localparam int ROUNDS = 16;
    localparam int LAT    = ROUNDS + 1;

    typedef struct packed {
        logic              vld;
        logic              dec;
        logic [HALF_W-1:0] l;
        logic [HALF_W-1:0] r;
        logic [CD_W-1:0]   c;
        logic [CD_W-1:0]   d;
    } stage_t;

    typedef struct packed {
        logic             vld;
        logic [BLK_W-1:0] blk;
    } out_t;

    // bit numbers count from 1 at the most significant end
    localparam int IP_T [64] = '{
        58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
        62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
        57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
        61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};
    localparam int P_T [32] = '{
        16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
        2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};
    localparam int PC1_T [56] = '{
        57,49,41,33,25,17,9,1,  58,50,42,34,26,18,10,2,
        59,51,43,35,27,19,11,3, 60,52,44,36,
        63,55,47,39,31,23,15,7, 62,54,46,38,30,22,14,6,
        61,53,45,37,29,21,13,5, 28,20,12,4};
    localparam int PC2_T [48] = '{
        14,17,11,24,1,5,3,28,   15,6,21,10,23,19,12,4,
        26,8,16,7,27,20,13,2,   41,52,31,37,47,55,30,40,
        51,45,33,48,44,49,39,56, 34,53,46,42,50,36,29,32};

    localparam int S1_T [64] = '{
        14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,   0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
        4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,   15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
    localparam int S2_T [64] = '{
        15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,   3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
        0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,   13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
    localparam int S3_T [64] = '{
        10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,   13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
        13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,   1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
    localparam int S4_T [64] = '{
        7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,   13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
        10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,   3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
    localparam int S5_T [64] = '{
        2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,   14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
        4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,   11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
    localparam int S6_T [64] = '{
        12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,   10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
        9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,   4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
    localparam int S7_T [64] = '{
        4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,   13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
        1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,   6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
    localparam int S8_T [64] = '{
        13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,   1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
        7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,   2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

    // left-rotation amount of encryption round rnd (1..16)
    function automatic int rot_amount(input int rnd);
        return (rnd == 1 || rnd == 2 || rnd == 9 || rnd == 16) ? 1 : 2;
    endfunction

    function automatic logic [63:0] init_perm(input logic [63:0] x);
        logic [63:0] y;
        y = '0;
        for (int j = 0; j < 64; j++) y[63-j] = x[64-IP_T[j]];
        return y;
    endfunction

    // inverse of init_perm, derived from the same table
    function automatic logic [63:0] final_perm(input logic [63:0] x);
        logic [63:0] y;
        y = '0;
        for (int j = 0; j < 64; j++) y[64-IP_T[j]] = x[63-j];
        return y;
    endfunction

    function automatic logic [47:0] expand(input logic [31:0] x);
        logic [47:0] y;
        int src;
        y = '0;
        for (int g = 0; g < 8; g++) begin
            for (int k = 0; k < 6; k++) begin
                src = 4*g + k;
                if (src == 0) src = 32;
                else if (src == 33) src = 1;
                y[47-(6*g+k)] = x[32-src];
            end
        end
        return y;
    endfunction

    function automatic logic [3:0] sbox_pick(input int box, input logic [5:0] idx);
        int v;
        case (box)
            0: v = S1_T[idx];
            1: v = S2_T[idx];
            2: v = S3_T[idx];
            3: v = S4_T[idx];
            4: v = S5_T[idx];
            5: v = S6_T[idx];
            6: v = S7_T[idx];
            default: v = S8_T[idx];
        endcase
        return 4'(v);
    endfunction

    function automatic logic [31:0] sbox_layer(input logic [47:0] x);
        logic [31:0] y;
        logic [5:0]  ch;
        y = '0;
        for (int g = 0; g < 8; g++) begin
            ch = x[47-6*g -: 6];
            y[31-4*g -: 4] = sbox_pick(g, {ch[5], ch[0], ch[4:1]});
        end
        return y;
    endfunction

    function automatic logic [31:0] perm_p(input logic [31:0] x);
        logic [31:0] y;
        y = '0;
        for (int j = 0; j < 32; j++) y[31-j] = x[32-P_T[j]];
        return y;
    endfunction

    function automatic logic [55:0] key_reduce(input logic [63:0] x);
        logic [55:0] y;
        y = '0;
        for (int j = 0; j < 56; j++) y[55-j] = x[64-PC1_T[j]];
        return y;
    endfunction

    function automatic logic [47:0] key_select(input logic [55:0] x);
        logic [47:0] y;
        y = '0;
        for (int j = 0; j < 48; j++) y[47-j] = x[56-PC2_T[j]];
        return y;
    endfunction

    function automatic logic [CD_W-1:0] rot_l(input logic [CD_W-1:0] x, input int n);
        case (n)
            1:       return {x[CD_W-2:0], x[CD_W-1]};
            2:       return {x[CD_W-3:0], x[CD_W-1:CD_W-2]};
            default: return x;
        endcase
    endfunction

    function automatic logic [CD_W-1:0] rot_r(input logic [CD_W-1:0] x, input int n);
        case (n)
            1:       return {x[0], x[CD_W-1:1]};
            2:       return {x[1:0], x[CD_W-1:2]};
            default: return x;
        endcase
    endfunction
endpackage

// File: rtl/des_key_step.sv
`timescale 1ns/100ps
module des_key_step
    import des_pkg::*;
#(
    parameter int ROUND = 1
) (
    input  logic              dec,
    input  logic [CD_W-1:0]   c_in,
    input  logic [CD_W-1:0]   d_in,
    output logic [CD_W-1:0]   c_out,
    output logic [CD_W-1:0]   d_out,
    output logic [SUBK_W-1:0] subkey
);
    localparam int ENC_SH = rot_amount(ROUND);
    // decryption: round 1 uses the unrotated halves, later rounds undo the
    // rotation of the mirrored encryption round
    localparam int DEC_SH = (ROUND == 1) ? 0 : rot_amount(ROUNDS + 2 - ROUND);

    always_comb begin
        if (dec) begin
            c_out = rot_r(c_in, DEC_SH);
            d_out = rot_r(d_in, DEC_SH);
        end else begin
            c_out = rot_l(c_in, ENC_SH);
            d_out = rot_l(d_in, ENC_SH);
        end
        subkey = key_select({c_out, d_out});
    end
endmodule

// File: rtl/des_round.sv
`timescale 1ns/100ps
module des_round
    import des_pkg::*;
(
    input  logic [HALF_W-1:0] l_in,
    input  logic [HALF_W-1:0] r_in,
    input  logic [SUBK_W-1:0] subkey,
    output logic [HALF_W-1:0] l_out,
    output logic [HALF_W-1:0] r_out
);
    logic [SUBK_W-1:0] mixed;
    logic [HALF_W-1:0] f_val;

    always_comb begin
        mixed = expand(r_in) ^ subkey;
        f_val = perm_p(sbox_layer(mixed));
        l_out = r_in;
        r_out = l_in ^ f_val;
    end
endmodule

// File: rtl/des_pipe_core.sv
`timescale 1ns/100ps
module des_pipe_core
    import des_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             in_decrypt,
    input  logic [BLK_W-1:0] in_key,
    input  logic [BLK_W-1:0] in_block,
    output logic             out_valid,
    output logic [BLK_W-1:0] out_block
);
    localparam int CNT_W = $clog2(LAT + 1);

    stage_t s_q [ROUNDS];
    stage_t s_d [ROUNDS];
    out_t   o_q;
    out_t   o_d;

    logic [HALF_W-1:0] rl [1:ROUNDS];
    logic [HALF_W-1:0] rr [1:ROUNDS];
    logic [CD_W-1:0]   rc [1:ROUNDS];
    logic [CD_W-1:0]   rd [1:ROUNDS];

    for (genvar i = 1; i <= ROUNDS; i++) begin : g_round
        logic [SUBK_W-1:0] k_i;

        des_key_step #(.ROUND(i)) u_key (
            .dec    (s_q[i-1].dec),
            .c_in   (s_q[i-1].c),
            .d_in   (s_q[i-1].d),
            .c_out  (rc[i]),
            .d_out  (rd[i]),
            .subkey (k_i)
        );

        des_round u_rnd (
            .l_in   (s_q[i-1].l),
            .r_in   (s_q[i-1].r),
            .subkey (k_i),
            .l_out  (rl[i]),
            .r_out  (rr[i])
        );
    end

    always_comb begin
        logic [BLK_W-1:0] ip_v;
        logic [55:0]      kr_v;
        ip_v = init_perm(in_block);
        kr_v = key_reduce(in_key);
        s_d[0] = '{vld: in_valid, dec: in_decrypt,
                   l: ip_v[BLK_W-1:HALF_W], r: ip_v[HALF_W-1:0],
                   c: kr_v[55:CD_W], d: kr_v[CD_W-1:0]};
        for (int i = 1; i < ROUNDS; i++) begin
            s_d[i] = '{vld: s_q[i-1].vld, dec: s_q[i-1].dec,
                       l: rl[i], r: rr[i], c: rc[i], d: rd[i]};
        end
        o_d.vld = s_q[ROUNDS-1].vld;
        o_d.blk = final_perm({rr[ROUNDS], rl[ROUNDS]});
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ROUNDS; i++) s_q[i] <= s_d[i];
        o_q <= o_d;
        if (rst) begin
            for (int i = 0; i < ROUNDS; i++) s_q[i].vld <= 1'b0;
            o_q.vld <= 1'b0;
        end
    end

    assign out_valid = o_q.vld;
    assign out_block = o_q.blk;

    // ---- assertions ----
    logic [CNT_W-1:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (rst)                        since_rst_q <= '0;
        else if (since_rst_q != CNT_W'(LAT)) since_rst_q <= since_rst_q + 1'b1;
    end

    // R6: nothing emerges before a full pipeline length has passed since reset
    p_quiet_after_reset_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (since_rst_q == CNT_W'(LAT)));

    // R2: every result traces back to a block taken LAT cycles before
    p_lat_fwd_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q == CNT_W'(LAT) && out_valid) |-> $past(in_valid, LAT));

    // R2: every block taken produces a result LAT cycles later
    p_lat_back_r2: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q == CNT_W'(LAT) && $past(in_valid, LAT)) |-> out_valid);

    // R1: encryption rotations add up to a full turn of each key half
    p_key_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (since_rst_q == CNT_W'(LAT) && s_q[ROUNDS-1].vld && !s_q[ROUNDS-1].dec)
        |-> ({rc[ROUNDS], rd[ROUNDS]} == $past({s_q[0].c, s_q[0].d}, ROUNDS-1)));
endmodule

// File: tb/des_pipe_core_tb_top.sv
`timescale 1ns/100ps
module des_pipe_core_tb_top;
    localparam int LATENCY = 17;
    localparam int NRAND   = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_decrypt = 1'b0;
    logic [63:0] in_key = '0;
    logic [63:0] in_block = '0;
    logic        out_valid;
    logic [63:0] out_block;

    int n_chk  = 0;
    int n_fail = 0;

    typedef struct {
        bit          vld;
        int          kind;   // 0: no value check, 1: compare, 2: capture
        logic [63:0] val;
        int          slot;
        string       req;
    } exp_t;

    exp_t        q[$];
    logic [63:0] r_key [NRAND];
    logic [63:0] r_pt  [NRAND];
    logic [63:0] r_ct  [NRAND];

    localparam logic [63:0] K1  = 64'h133457799BBCDFF1;
    localparam logic [63:0] P1  = 64'h0123456789ABCDEF;
    localparam logic [63:0] C1  = 64'h85E813540F0AB405;
    localparam logic [63:0] C0  = 64'h8CA64DE9C1B123A7;
    localparam logic [63:0] K2  = 64'h0E329232EA6D0D73;
    localparam logic [63:0] P2  = 64'h8787878787878787;
    localparam logic [63:0] K1P = 64'h123556789ABDDEF0;

    always #2.5 clk = ~clk;

    des_pipe_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_decrypt (in_decrypt),
        .in_key     (in_key),
        .in_block   (in_block),
        .out_valid  (out_valid),
        .out_block  (out_block)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic fill_idle();
        exp_t e;
        e = '{vld: 1'b0, kind: 0, val: '0, slot: 0, req: "R6"};
        q.delete();
        for (int i = 0; i < LATENCY; i++) q.push_back(e);
    endtask

    // one clock: compare the output due now, then present the next input
    task automatic step(input bit vld, input bit dec, input logic [63:0] key,
                        input logic [63:0] blk, input int kind,
                        input logic [63:0] val, input int slot, input string req);
        exp_t e;
        @(negedge clk);
        if (q.size() == LATENCY) begin
            e = q.pop_front();
            check(out_valid == e.vld, {e.req, " out_valid"}, 64'(out_valid), 64'(e.vld));
            if (e.vld && e.kind == 1) check(out_block === e.val, e.req, out_block, e.val);
            if (e.vld && e.kind == 2) r_ct[e.slot] = out_block;
        end
        in_valid   = vld;
        in_decrypt = dec;
        in_key     = key;
        in_block   = blk;
        e = '{vld: vld, kind: kind, val: val, slot: slot, req: req};
        q.push_back(e);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, 0, '0, 0, req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst      = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R6 reset clears out_valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        check(out_valid == 1'b0, "R6 reset holds out_valid", 64'(out_valid), 64'd0);
        fill_idle();
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

    initial begin
        do_reset();
        idle(LATENCY + 2, "R6");

        // R1 / R3: known answers back to back
        step(1'b1, 1'b0, K1, P1, 1, C1, 0, "R1 kat1");
        step(1'b1, 1'b0, '0, '0, 1, C0, 0, "R1 kat0");
        step(1'b1, 1'b0, K2, P2, 1, '0, 0, "R3 kat2 back-to-back");
        idle(4, "R2");

        // R4: inverse known answers
        step(1'b1, 1'b1, K1, C1, 1, P1, 0, "R4 dec kat1");
        step(1'b1, 1'b1, '0, C0, 1, '0, 0, "R4 dec kat0");
        idle(2, "R2");

        // R7: parity bits flipped
        step(1'b1, 1'b0, K1P, P1, 1, C1, 0, "R7 parity ignored");
        step(1'b1, 1'b1, K1P, C1, 1, P1, 0, "R7 parity ignored dec");

        // R5: random keys interleaved with known decrypts
        for (int i = 0; i < NRAND; i++) begin
            r_key[i] = {$urandom(), $urandom()};
            r_pt[i]  = {$urandom(), $urandom()};
            step(1'b1, 1'b0, r_key[i], r_pt[i], 2, '0, i, "R5 capture");
            if (i % 3 == 0) step(1'b1, 1'b1, K1, C1, 1, P1, 0, "R5 mixed mode");
            if (i % 5 == 4) idle(1, "R2");
        end
        idle(LATENCY, "R2");

        // R4 / R5: round trip of captured ciphertexts, mixed with encryptions
        for (int i = 0; i < NRAND; i++) begin
            step(1'b1, 1'b1, r_key[i], r_ct[i], 1, r_pt[i], 0, "R4 round trip");
            if (i % 4 == 1) step(1'b1, 1'b0, K2, P2, 1, '0, 0, "R5 mixed key");
        end
        idle(LATENCY, "R3");

        // R6: reset with blocks in flight
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, K1, P1, 1, C1, 0, "R6 pre");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, '0, 0, '0, 0, "R6 pre");
        do_reset();
        idle(LATENCY + 3, "R6 flushed");

        // R2: exact timing of the first block after reset
        step(1'b1, 1'b0, '0, '0, 1, C0, 0, "R2 after reset");
        idle(LATENCY + 1, "R2");

        finish_run();
    end
endmodule